// File: doc/BRIEF.md
# Sectored Flash Program/Erase Controller

This block holds the control logic of a byte-wide flash array with an 18-bit address space. It watches chip-enable, output-enable and write-enable bus cycles. It decodes unlocking command sequences for byte program, block erase and a boot-region lockout. It runs timed program and erase operations and reports their progress by data polling on the read path. For simulation the cell array is a small register file: each of the five blocks keeps `2**OFS_W` bytes, and these are indexed by the low address bits.

A write is taken on the clock where a sampled low write-enable is seen high again while chip-enable is low. Address and data are taken from the ports in that cycle. Operation lengths are parameters given in clock cycles, so a bench can shorten them. A power-on reset puts the array in its factory state. The bus reset only aborts the controller.

Top module: `flash_ctrl`

## Requirements
- R1: `data_oe_o` is 1 exactly when `ce_ni` and `oe_ni` are low and `we_ni` is high. While it is 0, `data_o` is 0x00. While it is 1 and nothing is busy, `data_o` is the stored byte at the decoded block and offset `addr_i[OFS_W-1:0]`.
- R2: Addresses decode to blocks as follows: 0x3C000 and above is boot, 0x3A000–0x3BFFF is parameter-high, 0x38000–0x39FFF is parameter-low, 0x20000–0x37FFF is main-high, and below 0x20000 is main-low.
- R3: The write sequence 0xAA@0x05555, 0x55@0x02AAA, 0xA0@0x05555, then a data write programs that address. The stored value becomes old AND new once `PROG_CYC` cycles have passed.
- R4: The write sequence 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, then 0x30 at any address erases that address's block to 0xFF once `ERASE_CYC` cycles have passed. No other block changes.
- R5: During a busy operation a read returns the complement of the target bit 7 on bit 7. The target bit 7 is 1 for an erase. Bit 6 starts at 0 when the operation begins and inverts after each completed read. Bits 5..0 are 0.
- R6: Writes made while busy are ignored and do not advance any command sequence.
- R7: A write that does not match the next expected cycle returns the decoder to read mode, and no operation starts.
- R8: The first five cycles of R4 followed by 0x40@0x05555 set the lockout. From then on, program and erase aimed at a boot address are dropped without going busy, and other blocks still operate.
- R9: Taking `rst_ni` low aborts an operation in progress without writing the array and returns to read mode. The lockout stays set.
- R10: `por_ni` low sets every stored byte to 0xFF and clears the lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; sets the factory state |
| rst_ni | input | 1 | Bus reset, active low, asynchronous; aborts the controller |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low; the write is taken on its rising edge |
| addr_i | input | 18 | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or polling status |
| data_oe_o | output | 1 | Read-data drive enable |

## Verification
The bound checker checks four things on every cycle. No operation starts while one is running. No boot-targeted operation starts after lockout, and the lockout never clears except through power-on reset. During a busy read the low status bits stay at zero, and a finished operation drops busy. The bench scenarios cover behaviour that spans many cycles: the exact AND and erase results, the block boundaries seen through aliased offsets, the toggle sequence across successive polls, rejected and busy-time command sequences, and the fact that an aborted program leaves the array as it was.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int ADDR_W  = 18;
  localparam int DATA_W  = 8;
  localparam int NUM_BLK = 5;

  typedef enum logic [2:0] {BLK_MAIN_LO, BLK_MAIN_HI, BLK_PAR_LO, BLK_PAR_HI, BLK_BOOT} blk_e;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_e;

  localparam logic [ADDR_W-1:0] UNLOCK_A = 18'h05555;
  localparam logic [ADDR_W-1:0] UNLOCK_B = 18'h02AAA;
  localparam logic [DATA_W-1:0] KEY_A    = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_B    = 8'h55;
  localparam logic [DATA_W-1:0] C_PROG   = 8'hA0;
  localparam logic [DATA_W-1:0] C_SETUP  = 8'h80;
  localparam logic [DATA_W-1:0] C_ERASE  = 8'h30;
  localparam logic [DATA_W-1:0] C_LOCK   = 8'h40;

  localparam logic [ADDR_W-1:0] BASE_BOOT   = 18'h3C000;
  localparam logic [ADDR_W-1:0] BASE_PAR_HI = 18'h3A000;
  localparam logic [ADDR_W-1:0] BASE_PAR_LO = 18'h38000;
  localparam logic [ADDR_W-1:0] BASE_MAIN_HI = 18'h20000;

  function automatic blk_e blk_of(logic [ADDR_W-1:0] a);
    if (a >= BASE_BOOT)         return BLK_BOOT;
    else if (a >= BASE_PAR_HI)  return BLK_PAR_HI;
    else if (a >= BASE_PAR_LO)  return BLK_PAR_LO;
    else if (a >= BASE_MAIN_HI) return BLK_MAIN_HI;
    else                        return BLK_MAIN_LO;
  endfunction
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_o,
  output op_e               op_o,
  output logic              lock_set_o
);
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_SET, S_SU1, S_SU2} seq_e;
  seq_e state_q, state_d;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                               logic [ADDR_W-1:0] ea, logic [DATA_W-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  always_comb begin
    state_d    = state_q;
    start_o    = 1'b0;
    op_o       = OP_PROG;
    lock_set_o = 1'b0;
    if (wr_i) begin
      state_d = S_IDLE;  // any mismatch falls back to read mode
      case (state_q)
        S_IDLE: if (hit(addr_i, data_i, UNLOCK_A, KEY_A)) state_d = S_U1;
        S_U1:   if (hit(addr_i, data_i, UNLOCK_B, KEY_B)) state_d = S_U2;
        S_U2: begin
          if (hit(addr_i, data_i, UNLOCK_A, C_PROG))       state_d = S_PGM;
          else if (hit(addr_i, data_i, UNLOCK_A, C_SETUP)) state_d = S_SET;
        end
        S_PGM:  start_o = 1'b1;
        S_SET:  if (hit(addr_i, data_i, UNLOCK_A, KEY_A)) state_d = S_SU1;
        S_SU1:  if (hit(addr_i, data_i, UNLOCK_B, KEY_B)) state_d = S_SU2;
        S_SU2: begin
          if (data_i == C_ERASE) begin
            start_o = 1'b1;
            op_o    = OP_ERASE;
          end else if (hit(addr_i, data_i, UNLOCK_A, C_LOCK)) begin
            lock_set_o = 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_pkg::*;
#(
  parameter int PROG_CYC  = 12500,
  parameter int ERASE_CYC = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= (op_i == OP_ERASE) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              commit_i,
  input  op_e               op_i,
  input  blk_e              blk_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] data_i,
  input  blk_e              rd_blk_i,
  input  logic [OFS_W-1:0]  rd_ofs_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH     = 1 << OFS_W;
  localparam int BLK_SLOTS = 1 << $bits(blk_e);

  logic [DATA_W-1:0] rd_bus [BLK_SLOTS];

  for (genvar b = 0; b < BLK_SLOTS; b++) begin : g_blk
    if (b < NUM_BLK) begin : g_used
      logic [DATA_W-1:0] cell_q [DEPTH];
      logic              sel;
      assign sel = commit_i && (blk_i == blk_e'(b));

      always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
          for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
        end else if (sel) begin
          if (op_i == OP_ERASE) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
          end else begin
            cell_q[ofs_i] <= cell_q[ofs_i] & data_i;  // bits only clear
          end
        end
      end
      assign rd_bus[b] = cell_q[rd_ofs_i];
    end else begin : g_none
      assign rd_bus[b] = '1;
    end
  end

  assign rd_data_o = rd_bus[rd_blk_i];
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int PROG_CYC  = 12500,
  parameter int ERASE_CYC = 250000,
  parameter int OFS_W     = 2
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic ctl_rst_n;
  assign ctl_rst_n = por_ni & rst_ni;

  logic we_q, rd_q, rd_act, wr_stb;
  logic busy, done;
  logic seq_start, seq_lock, start_ok;
  op_e  seq_op;
  blk_e in_blk;

  op_e               op_q;
  blk_e              blk_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] dat_q;
  logic              poll_b7_q, toggle_q, lock_q;
  logic [DATA_W-1:0] rd_data;

  assign in_blk   = blk_of(addr_i);
  assign rd_act   = !ce_ni && !oe_ni && we_ni;
  assign wr_stb   = !ce_ni && !we_q && we_ni && !busy;
  assign start_ok = seq_start && !(lock_q && in_blk == BLK_BOOT);

  always_ff @(posedge clk_i or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      we_q <= 1'b1;
      rd_q <= 1'b0;
    end else begin
      we_q <= we_ni;
      rd_q <= rd_act;
    end
  end

  flash_cmd_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (ctl_rst_n),
    .wr_i       (wr_stb),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .start_o    (seq_start),
    .op_o       (seq_op),
    .lock_set_o (seq_lock)
  );

  flash_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (ctl_rst_n),
    .start_i (start_ok),
    .op_i    (seq_op),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      op_q      <= OP_NONE;
      blk_q     <= BLK_MAIN_LO;
      ofs_q     <= '0;
      dat_q     <= '1;
      poll_b7_q <= 1'b1;
      toggle_q  <= 1'b0;
    end else if (start_ok) begin
      op_q      <= seq_op;
      blk_q     <= in_blk;
      ofs_q     <= addr_i[OFS_W-1:0];
      dat_q     <= data_i;
      poll_b7_q <= (seq_op == OP_ERASE) ? 1'b1 : data_i[7];
      toggle_q  <= 1'b0;
    end else if (busy && rd_q && !rd_act) begin
      toggle_q  <= ~toggle_q;
    end
  end

  // lockout survives bus reset; only power-on clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)       lock_q <= 1'b0;
    else if (seq_lock) lock_q <= 1'b1;
  end

  flash_store #(.OFS_W(OFS_W)) i_store (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .commit_i  (done),
    .op_i      (op_q),
    .blk_i     (blk_q),
    .ofs_i     (ofs_q),
    .data_i    (dat_q),
    .rd_blk_i  (in_blk),
    .rd_ofs_i  (addr_i[OFS_W-1:0]),
    .rd_data_o (rd_data)
  );

  assign data_oe_o = rd_act;
  always_comb begin
    if (!rd_act)   data_o = '0;
    else if (busy) data_o = {~poll_b7_q, toggle_q, 6'b0};
    else           data_o = rd_data;
  end
endmodule

// File: rtl/flash_ctrl_chk.sv
module flash_ctrl_chk
  import flash_pkg::*;
(
  input logic              clk_i,
  input logic              por_ni,
  input logic              rst_ni,
  input logic              busy,
  input logic              done,
  input logic              start_ok,
  input blk_e              in_blk,
  input logic              lock_q,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o
);
  p_quiet_bus_r1: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    !data_oe_o |-> data_o == '0);
  p_start_goes_busy_r3: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    start_ok |=> busy);
  p_done_drops_busy_r3: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    done |=> !busy);
  p_status_low_zero_r5: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    busy && data_oe_o |-> data_o[5:0] == 6'd0);
  p_no_start_busy_r6: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    busy |-> !start_ok);
  p_boot_guard_r8: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    lock_q && start_ok |-> in_blk != BLK_BOOT);
  p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
    lock_q |=> lock_q);
  p_reset_idle_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rst_ni |-> !busy);
endmodule

bind flash_ctrl flash_ctrl_chk i_chk (
  .clk_i     (clk_i),
  .por_ni    (por_ni),
  .rst_ni    (rst_ni),
  .busy      (busy),
  .done      (done),
  .start_ok  (start_ok),
  .in_blk    (in_blk),
  .lock_q    (lock_q),
  .data_oe_o (data_oe_o),
  .data_o    (data_o)
);

// File: tb/test_flash_ctrl.sv
`timescale 1ns/1ps
module test_flash_ctrl;
  localparam int PROG  = 40;
  localparam int ERASE = 80;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;

  always #2 clk = ~clk;

  flash_ctrl #(.PROG_CYC(PROG), .ERASE_CYC(ERASE), .OFS_W(2)) i_flash_ctrl (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n),
    .we_ni(we_n), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       smp = 1'b0;
  bit         ended = 1'b0;

  // monitor: compares each read against the expected item
  always @(negedge clk) begin
    if (smp) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (!doe || dout !== e) begin
        n_bad++;
        $display("FAIL %s: got %h (oe %0b) expected %h", t, dout, doe, e);
      end
    end
  end

  task automatic chk(input logic [7:0] got, input logic [7:0] e, input string t);
    n_vec++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, got, e);
    end
  endtask

  task automatic rd(input logic [17:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t); smp = 1'b1;
    @(posedge clk); #1;
    smp = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(posedge clk); #1;
    we_n = 1'b1;
    @(posedge clk); #1;
    ce_n = 1'b1;
  endtask

  task automatic prog(input logic [17:0] a, input logic [7:0] d);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic setup6(input logic [17:0] a, input logic [7:0] d);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h80);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(a, d);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    waitc(3); #1;
    por_n = 1'b1; rst_n = 1'b1;
    waitc(2);

    // R10 factory state, R1 idle bus
    @(negedge clk);
    chk(dout, 8'h00, "R1 idle data");
    chk({7'd0, doe}, 8'h00, "R1 idle oe");
    rd(18'h00000, 8'hFF, "R10 erased after por");
    rd(18'h3C002, 8'hFF, "R10 boot erased");
    // R1: oe gated off while we low
    @(posedge clk); #1; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk); chk({7'd0, doe}, 8'h00, "R1 oe with we low");
    #1; ce_n = 1'b1; @(posedge clk); #1; we_n = 1'b1; oe_n = 1'b1;

    // R3 + R5 polling on a boot program
    prog(18'h3C001, 8'h5A);
    rd(18'h3C001, 8'h80, "R5 poll first");
    rd(18'h3C001, 8'hC0, "R5 poll toggled");
    rd(18'h3C001, 8'h80, "R5 poll toggled back");
    waitc(PROG);
    rd(18'h3C001, 8'h5A, "R3 program result");

    // R2 block map: each block at offset 3
    prog(18'h3A003, 8'h31); waitc(PROG + 2);
    prog(18'h38003, 8'h32); waitc(PROG + 2);
    prog(18'h37FFF, 8'h33); waitc(PROG + 2);
    prog(18'h1FFFF, 8'h34); waitc(PROG + 2);
    prog(18'h3FFFF, 8'h35); waitc(PROG + 2);
    rd(18'h3BFFF, 8'h31, "R2 par_hi top");
    rd(18'h39FFF, 8'h32, "R2 par_lo top");
    rd(18'h20003, 8'h33, "R2 main_hi base");
    rd(18'h00003, 8'h34, "R2 main_lo base");
    rd(18'h3C003, 8'h35, "R2 boot base");

    // R3 AND semantics
    prog(18'h3A003, 8'h0F); waitc(PROG + 2);
    rd(18'h3A003, 8'h01, "R3 and of old and new");

    // R6 writes during busy dropped
    prog(18'h38001, 8'h00);
    prog(18'h38002, 8'h00);
    waitc(PROG + 2);
    rd(18'h38001, 8'h00, "R6 first program");
    rd(18'h38002, 8'hFF, "R6 busy-time program ignored");
    rd(18'h38002, 8'hFF, "R6 not busy after");

    // R7 wrong unlock cycle
    wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00002, 8'h00);
    rd(18'h00002, 8'hFF, "R7 no operation started");
    prog(18'h00002, 8'hF0);
    waitc(PROG + 2);
    rd(18'h00002, 8'hF0, "R7 recovers to read mode");

    // R4 erase of par_hi
    setup6(18'h3A000, 8'h30);
    rd(18'h3A003, 8'h00, "R4 erase poll");
    waitc(ERASE + 2);
    rd(18'h3A003, 8'hFF, "R4 block erased");
    rd(18'h38003, 8'h32, "R4 neighbour untouched");

    // R9 abort
    prog(18'h00001, 8'h00);
    rd(18'h00001, 8'h80, "R9 busy before abort");
    @(posedge clk); #1; rst_n = 1'b0;
    waitc(2); #1; rst_n = 1'b1;
    rd(18'h00001, 8'hFF, "R9 aborted no commit");
    waitc(PROG + 2);
    rd(18'h00001, 8'hFF, "R9 still unwritten");

    // R8 lockout
    setup6(18'h05555, 8'h40);
    prog(18'h3C000, 8'h00);
    rd(18'h3C000, 8'hFF, "R8 boot program dropped");
    setup6(18'h3C000, 8'h30);
    rd(18'h3FFFF, 8'h35, "R8 boot erase dropped");
    prog(18'h20000, 8'h70);
    waitc(PROG + 2);
    rd(18'h20000, 8'h70, "R8 other block programs");
    @(posedge clk); #1; rst_n = 1'b0;
    waitc(2); #1; rst_n = 1'b1;
    prog(18'h3C000, 8'h00);
    waitc(PROG + 2);
    rd(18'h3C000, 8'hFF, "R9 lockout kept over reset");

    // R10 power-on clears array and lockout
    @(posedge clk); #1; por_n = 1'b0;
    waitc(2); #1; por_n = 1'b1;
    rd(18'h3FFFF, 8'hFF, "R10 boot reset to ff");
    rd(18'h20000, 8'hFF, "R10 main reset to ff");
    prog(18'h3C000, 8'h12);
    waitc(PROG + 2);
    rd(18'h3C000, 8'h12, "R10 lockout cleared");

    waitc(2);
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule